// File: doc/BRIEF.md
# PWM Generator with Lock-Gated Atomic Update

This block produces one pulse-width-modulated output from a free-running counter. Software programs a period, a duty length and a polarity through a small word-addressed register port. Writes to period and duty land in staging registers. A separate set of active registers drives the comparison, so a new setting never reaches the output in the middle of a period.

A lock bit in the control word freezes the active set while software rewrites several fields. This covers any number of writes to period, duty and the polarity bits. When software clears the lock, the staged period, staged duty and the polarity carried by that clearing write are armed. All three switch over together on the next counter wrap.

Without the lock, each write still waits for the next wrap before it takes effect. Enabling the generator from the disabled state loads the staged values at once and restarts the count from zero.

Top module: `pwm_atomic`

## Requirements
- R1: After reset the output is 0 and reads of all four registers (word index 0 counter, 1 period, 2 duty, 3 control) return 0.
- R2: While the enable (control bit 0) is 0 and the lock is 0, the counter reads 0 and the output settles to the idle level given by control bit 4 (1 = idle high).
- R3: While enabled, the counter steps by one per clock from 0 to period-1 and then wraps to 0. A read of word 0 returns the live count, and writes to word 0 have no effect on it.
- R4: With control bit 5 at 0 (left-aligned), the output is in its active phase while the count is below the duty. The active level is control bit 3 (1 = high) and the level outside the active phase is control bit 4. The output is registered and shows the level for a count one clock after that count.
- R5: With the lock at 0, a write to period, duty or the polarity bits takes effect at the first counter wrap after the write, never earlier.
- R6: While control bit 6 (lock) is 1 and the block is enabled, writes to period, duty, and the polarity and alignment bits (including those in the locking write itself) leave the output waveform unchanged.
- R7: A control write that clears the lock makes the staged period, the staged duty and the polarity in that write active together at the next counter wrap.
- R8: A duty at or above the period gives a constantly active output. A period of 0 gives a constantly idle output.
- R9: Reads are registered, with the data one clock after the address. Reads of period and duty return the staged values. A read of control returns enable, duty level, idle level, alignment and lock in bits 0, 3, 4, 5 and 6.
- R10: A control write that sets the enable while it is 0 makes the staged period, duty and that write's polarity active at once, even if a lock was set, and restarts the count at 0.
- R11: With control bit 5 at 1 (right-aligned), the output is active during the last duty counts of each period, that is, while count is at least period minus duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Word index: 0 counter, 1 period, 2 duty, 3 control |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data for the previous cycle's address |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bound checker covers the rules that hold on every clock:
- The count stays below a nonzero active period and steps by exactly one between wraps.
- The active period and duty change only where the count has returned to zero.
- The active values stay frozen whenever the block is enabled and locked.
- The output follows the active idle level while disabled.

The bench's scenarios are needed for the rules that depend on the exact waveform:
- The shape of left- and right-aligned pulses.
- The exact wrap at which a write or an unlock takes effect.
- A polarity change held back by the lock.
- The duty and period corner cases.
- The immediate load on enable.
- Register read-back.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // word indices of the register port
  localparam int unsigned REG_CNT  = 0;
  localparam int unsigned REG_PER  = 1;
  localparam int unsigned REG_DUTY = 2;
  localparam int unsigned REG_CTRL = 3;

  // control word bit positions
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_DHI   = 3;
  localparam int unsigned B_IDLE  = 4;
  localparam int unsigned B_ALIGN = 5;
  localparam int unsigned B_LOCK  = 6;

  typedef struct packed {
    logic align;    // 0 left-aligned, 1 right-aligned
    logic idle;     // level outside the active phase
    logic duty_hi;  // level during the active phase
  } pol_t;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     cnt,
  output logic [DW-1:0]     per_s,
  output logic [DW-1:0]     duty_s,
  output logic              en,
  output logic              lock,
  output pol_t              pol_s,
  output pol_t              pol_wr,
  output logic              arm,
  output logic              en_rise,
  output logic [DW-1:0]     rdata
);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(REG_CNT);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(REG_PER);
  localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(REG_DUTY);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);

  logic          wr_per, wr_duty, wr_ctrl;
  logic [DW-1:0] ctrl_word;
  logic [DW-1:0] rd_nx;

  assign wr_per  = we && (addr == A_PER);
  assign wr_duty = we && (addr == A_DUTY);
  assign wr_ctrl = we && (addr == A_CTRL);

  assign pol_wr.align   = wdata[B_ALIGN];
  assign pol_wr.idle    = wdata[B_IDLE];
  assign pol_wr.duty_hi = wdata[B_DHI];

  // a commit is armed by any timing write outside the lock, or by a
  // control write that leaves the lock clear
  assign arm     = ((wr_per || wr_duty) && !lock) || (wr_ctrl && !wdata[B_LOCK]);
  assign en_rise = wr_ctrl && wdata[B_EN] && !en;

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[B_EN]    = en;
    ctrl_word[B_DHI]   = pol_s.duty_hi;
    ctrl_word[B_IDLE]  = pol_s.idle;
    ctrl_word[B_ALIGN] = pol_s.align;
    ctrl_word[B_LOCK]  = lock;
  end

  always_comb begin
    case (addr)
      A_CNT:   rd_nx = cnt;
      A_PER:   rd_nx = per_s;
      A_DUTY:  rd_nx = duty_s;
      A_CTRL:  rd_nx = ctrl_word;
      default: rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_s  <= '0;
      duty_s <= '0;
      en     <= 1'b0;
      lock   <= 1'b0;
      pol_s  <= '0;
      rdata  <= '0;
    end else begin
      if (wr_per)  per_s  <= wdata;
      if (wr_duty) duty_s <= wdata;
      if (wr_ctrl) begin
        en    <= wdata[B_EN];
        lock  <= wdata[B_LOCK];
        pol_s <= pol_wr;
      end
      rdata <= rd_nx;
    end
  end
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] per_s,
  input  logic [DW-1:0] duty_s,
  input  pol_t          pol_s,
  input  pol_t          pol_wr,
  input  logic          en,
  input  logic          lock,
  input  logic          arm,
  input  logic          en_rise,
  input  logic          wrap,
  output logic [DW-1:0] per_a,
  output logic [DW-1:0] duty_a,
  output pol_t          pol_a
);
  logic pending;
  logic load;
  logic commit;

  // immediate load on enable, or while idle and unlocked
  assign load   = en_rise || (!en && !lock);
  // deferred commit only at a wrap with the lock released
  assign commit = en && pending && !lock && wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_a   <= '0;
      duty_a  <= '0;
      pol_a   <= '0;
      pending <= 1'b0;
    end else begin
      if (load) begin
        per_a  <= per_s;
        duty_a <= duty_s;
        pol_a  <= en_rise ? pol_wr : pol_s;
      end else if (commit) begin
        per_a  <= per_s;
        duty_a <= duty_s;
        pol_a  <= pol_s;
      end
      // a fresh arm wins so that values written at a commit edge are not lost
      if (arm)                 pending <= 1'b1;
      else if (load || commit) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] per_a,
  input  logic [DW-1:0] duty_a,
  input  pol_t          pol_a,
  output logic [DW-1:0] cnt,
  output logic          wrap,
  output logic          pwm_out
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic act;
  logic lvl_nx;

  assign wrap = en && ((per_a == '0) || (cnt == per_a - ONE));

  always_comb begin
    if (pol_a.align) act = (duty_a >= per_a) || (cnt >= per_a - duty_a);
    else             act = (cnt < duty_a);
  end

  assign lvl_nx = (!en || (per_a == '0)) ? pol_a.idle
                                         : (act ? pol_a.duty_hi : pol_a.idle);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pwm_out <= 1'b0;
    end else begin
      if (!en || wrap) cnt <= '0;
      else             cnt <= cnt + ONE;
      pwm_out <= lvl_nx;
    end
  end
endmodule

// File: rtl/pwm_atomic.sv
module pwm_atomic
  import pwm_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              pwm_out
);
  logic [DW-1:0] per_s, duty_s, per_a, duty_a, cnt;
  logic          en_q, lock_q, arm, en_rise, wrap;
  pol_t          pol_s, pol_wr, pol_a;

  pwm_regfile #(.DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .cnt     (cnt),
    .per_s   (per_s),
    .duty_s  (duty_s),
    .en      (en_q),
    .lock    (lock_q),
    .pol_s   (pol_s),
    .pol_wr  (pol_wr),
    .arm     (arm),
    .en_rise (en_rise),
    .rdata   (bus_rdata)
  );

  pwm_shadow #(.DW(DW)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .per_s   (per_s),
    .duty_s  (duty_s),
    .pol_s   (pol_s),
    .pol_wr  (pol_wr),
    .en      (en_q),
    .lock    (lock_q),
    .arm     (arm),
    .en_rise (en_rise),
    .wrap    (wrap),
    .per_a   (per_a),
    .duty_a  (duty_a),
    .pol_a   (pol_a)
  );

  pwm_core #(.DW(DW)) u_core (
    .clk     (clk),
    .rst     (rst),
    .en      (en_q),
    .per_a   (per_a),
    .duty_a  (duty_a),
    .pol_a   (pol_a),
    .cnt     (cnt),
    .wrap    (wrap),
    .pwm_out (pwm_out)
  );
endmodule

// File: rtl/pwm_atomic_chk.sv
module pwm_atomic_chk
  import pwm_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          lock,
  input logic [DW-1:0] per_a,
  input logic [DW-1:0] duty_a,
  input pol_t          pol_a,
  input logic [DW-1:0] cnt,
  input logic          pwm_out
);
  // R2: disabled output follows the active idle level
  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> pwm_out == $past(pol_a.idle));

  // R3: count stays inside a nonzero period
  p_count_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    (en && per_a != '0) |-> cnt < per_a);

  // R3: count advances by one between wraps
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && cnt != '0) |-> cnt == $past(cnt) + DW'(1));

  // R5: active timing changes only at a period boundary
  p_commit_on_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && (per_a != $past(per_a) || duty_a != $past(duty_a)))
      |-> cnt == '0);

  // R6: locked and enabled freezes every active field
  p_lock_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    (en && lock) |=> ($stable(per_a) && $stable(duty_a) && $stable(pol_a)));
endmodule

bind pwm_atomic pwm_atomic_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en_q),
  .lock    (lock_q),
  .per_a   (per_a),
  .duty_a  (duty_a),
  .pol_a   (pol_a),
  .cnt     (cnt),
  .pwm_out (pwm_out)
);

// File: tb/pwm_atomic_test.sv
module pwm_atomic_test;
  localparam int BIG = 32'h7fff_fff0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         pwm_out;

  always #4 clk = ~clk;

  pwm_atomic uut (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (we),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .pwm_out   (pwm_out)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  // expected configuration: current and pending-from-edge sw
  int o_per, o_duty, o_base;
  bit o_dh, o_id, o_al;
  int n_per, n_duty;
  bit n_dh, n_id, n_al;
  int sw = BIG;

  function automatic logic [31:0] ctl(bit en, bit dh, bit id, bit al, bit lk);
    return {25'd0, lk, al, id, dh, 2'b00, en};
  endfunction

  function automatic bit lvl(int per, int duty, bit dh, bit id, bit al, int c);
    bit act;
    if (per == 0) return id;
    if (al) act = (duty >= per) || (c >= per - duty);
    else    act = (c < duty);
    return act ? dh : id;
  endfunction

  // output seen after edge m reflects count after edge m-1
  function automatic bit exp_out(int m);
    int k = m - 1;
    if (k >= sw) return lvl(n_per, n_duty, n_dh, n_id, n_al, (n_per == 0) ? 0 : (k - sw) % n_per);
    return lvl(o_per, o_duty, o_dh, o_id, o_al, (o_per == 0) ? 0 : (k - o_base) % o_per);
  endfunction

  function automatic int next_wrap(int u);
    int w = u + 1;
    if (o_per != 0) while (((w - o_base) % o_per) != 0) w++;
    return w;
  endfunction

  task automatic set_now(int per, int duty, bit dh, bit id, bit al, int base);
    o_per = per; o_duty = duty; o_dh = dh; o_id = id; o_al = al; o_base = base; sw = BIG;
  endtask

  task automatic set_next(int per, int duty, bit dh, bit id, bit al, int at);
    n_per = per; n_duty = duty; n_dh = dh; n_id = id; n_al = al; sw = at;
  endtask

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = 2'(a); wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    addr = 2'(a);
    @(posedge clk);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic watch(int n, string tag);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      chk({31'd0, pwm_out}, {31'd0, exp_out(cyc)}, tag);
    end
    if (sw != BIG && cyc - 1 >= sw)
      set_now(n_per, n_duty, n_dh, n_id, n_al, sw);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk({31'd0, pwm_out}, 32'd0, "R1 output");
    for (int a = 0; a < 4; a++) begin
      rd(a, d);
      chk(d, 32'd0, "R1 register");
    end
  endtask

  task automatic t_basic;
    logic [31:0] d;
    wr(1, 10);
    wr(2, 3);
    wr(3, ctl(1, 1, 0, 0, 0));
    set_now(10, 3, 1, 0, 0, cyc);
    watch(25, "R4 left-aligned");
    rd(0, d);
    chk(d, 32'((cyc - 1 - o_base) % 10), "R3 live count");
    rd(1, d); chk(d, 10, "R9 period read");
    rd(2, d); chk(d, 3, "R9 duty read");
    rd(3, d); chk(d, ctl(1, 1, 0, 0, 0), "R9 control read");
    wr(0, 32'h55);
    rd(0, d);
    chk(d, 32'((cyc - 1 - o_base) % 10), "R3 count write ignored");
    watch(5, "R3 count write ignored");
  endtask

  task automatic t_unlocked;
    int u;
    wr(2, 7);
    u = cyc;
    set_next(10, 7, 1, 0, 0, next_wrap(u));
    watch(30, "R5 duty at wrap");
    wr(3, ctl(1, 0, 1, 0, 0));
    u = cyc;
    set_next(10, 7, 0, 1, 0, next_wrap(u));
    watch(25, "R5 polarity at wrap");
  endtask

  task automatic t_lock;
    logic [31:0] d;
    int u;
    wr(3, ctl(1, 1, 0, 0, 1));   // lock, with a differing polarity
    wr(1, 6);
    wr(2, 2);
    watch(25, "R6 locked hold");
    rd(1, d); chk(d, 6, "R9 staged period while locked");
    wr(3, ctl(1, 1, 0, 0, 0));
    u = cyc;
    set_next(6, 2, 1, 0, 0, next_wrap(u));
    watch(25, "R7 unlock commit");
  endtask

  task automatic t_corner;
    logic [31:0] d;
    wr(3, ctl(0, 0, 1, 0, 0));
    repeat (3) begin @(posedge clk); @(negedge clk); end
    chk({31'd0, pwm_out}, 32'd1, "R2 idle high when off");
    rd(0, d); chk(d, 0, "R2 count held at zero");
    wr(1, 4);
    wr(2, 4);
    wr(3, ctl(1, 1, 0, 0, 0));
    set_now(4, 4, 1, 0, 0, cyc);
    watch(12, "R8 duty equals period");
    wr(3, ctl(0, 0, 1, 0, 0));
    wr(1, 0);
    wr(3, ctl(1, 0, 1, 0, 0));
    set_now(0, 4, 0, 1, 0, cyc);
    watch(10, "R8 period zero");
    wr(3, ctl(0, 1, 0, 0, 1));   // disabled and locked
    wr(1, 5);
    wr(2, 1);
    wr(3, ctl(1, 1, 0, 0, 0));
    set_now(5, 1, 1, 0, 0, cyc);
    watch(15, "R10 load on enable");
  endtask

  task automatic t_right;
    wr(3, ctl(0, 1, 0, 0, 0));
    wr(1, 8);
    wr(2, 3);
    wr(3, ctl(1, 1, 0, 1, 0));
    set_now(8, 3, 1, 0, 1, cyc);
    watch(24, "R11 right-aligned");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset;
    t_basic;
    t_unlocked;
    t_lock;
    t_corner;
    t_right;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule